// File: doc/BRIEF.md
# Mapped Interrupt Router

This block gathers sixteen interrupt requests and steers each one to one of up to eight CPU interrupt lines. Five of the requests come from an external bus. Each of these passes a two-flop synchronizer and a per-input conditioner. The conditioner selects the active polarity and chooses between edge and level detection. The other eleven requests are synchronous on-chip strobes. Every request is held in a pending bit that stays set until software clears it by writing ones.

Software programs the block over a simple 32-bit register bus: address, write strobe, write data and read data, with reads returning data in the same cycle. Each source owns a 4-bit routing nibble. That nibble holds a 3-bit destination line number and an enable. A one-shot "retarget all" write moves every source to a single destination and leaves the enables as they are. Each CPU line has its own master enable. Software can read, per CPU line, which pending sources point at that line.

Top module: `irq_router`

## Requirements
- R1: After reset, all routing nibbles, the line enables and the external-input configuration are zero, no source is pending, every register reads 0 and every `cpu_irq_o` bit is low.
- R2: Source k owns the nibble at bits 4*(k mod 8) of the routing word at byte address 0x00 (k < 8) or 0x04 (k >= 8). Within the nibble, bits [2:0] give the destination line and bit 3 enables the source. Both routing words read back exactly what was written.
- R3: `cpu_irq_o[n]` is high exactly when bit 16+n of the line-enable register (address 0x20) is set and at least one source is pending, enabled and routed to n. The output follows register state combinationally, in the same cycle.
- R4: A read of address 0x10+4*j returns, for line 2j in bits [15:0] and for line 2j+1 in bits [31:16], one bit per source that is pending and routed to that line. Pending sources whose enable is clear are included.
- R5: A write to address 0x0C clears, at that clock edge, the pending bit of every source whose data bit is 1. Bits written as 0 change nothing, and the address reads 0. A new request arriving in the same cycle wins over the clear.
- R6: A write to address 0x08 sets the destination of all sixteen nibbles to data bits [2:0]. It leaves every enable bit unchanged, and the address reads 0.
- R7: External input i (sources 0 to 4) is configured by bits 2i (1 = active low) and 2i+1 (1 = level mode) of address 0x24. Its pending bit sets on the third rising clock edge after the input reaches its active state.
- R8: In edge mode an external input sets pending once per inactive-to-active transition. The bit stays set after the input goes inactive until it is cleared.
- R9: In level mode an external input sets pending on every cycle it is active, so a clear issued while the input is still active has no lasting effect.
- R10: An on-chip source (index 5 to 15, pin `int_irq_i[k-5]`) that is high at a clock edge sets its pending bit at that edge. The bit is sticky until cleared.
- R11: Addresses other than those listed read 0, and writes to them change no state. Unimplemented bits of registers 0x20 and 0x24 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq_i | input | 5 | Asynchronous external bus interrupt pins (sources 0..4) |
| int_irq_i | input | 11 | Synchronous on-chip request strobes (sources 5..15) |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| cpu_irq_o | output | 8 | CPU interrupt lines |

## Verification
Several properties hold on every cycle and are checked by assertions. A write-one clear always empties the addressed pending bits unless a new request arrives in the same cycle. Pending bits never drop without a clear. An edge-mode conditioner never fires two cycles in a row. The retarget-all write never disturbs an enable. A CPU line is never raised while nothing is pending. Only the bench scenarios can show the rest: the exact three-edge latency through the synchronizer, polarity inversion, the level-mode clear that does not take effect, the status word packing, and the routing of every source under mixed traffic, all compared against a behavioural model on every clock.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int FLD_W         = 4;
  localparam int FLDS_PER_WORD = 8;
  localparam int DEST_W        = 3;
  localparam int OUTEN_LSB     = 16;

  localparam int AD_ROUTE  = 'h00;
  localparam int AD_MAPALL = 'h08;
  localparam int AD_CLEAR  = 'h0C;
  localparam int AD_STAT   = 'h10;
  localparam int AD_OUTEN  = 'h20;
  localparam int AD_EXTCFG = 'h24;

  typedef struct packed {
    logic              en;
    logic [DEST_W-1:0] dest;
  } src_fld_t;

  function automatic src_fld_t fld_of(input logic [FLD_W-1:0] raw);
    return src_fld_t'(raw);
  endfunction

  function automatic logic [31:0] remap_word(input logic [31:0] old,
                                             input logic [DEST_W-1:0] dest);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < FLDS_PER_WORD; i++) r[i*FLD_W +: DEST_W] = dest;
    return r;
  endfunction

  function automatic logic [31:0] pack_stat(input logic [15:0] lo,
                                            input logic [15:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/irq_cond.sv
module irq_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic low_act_i,
  input  logic level_i,
  output logic set_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   act_w;
  logic                   rise_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= act_w;
    end
  end

  assign act_w  = sync_q[SYNC_STAGES-1] ^ low_act_i;
  assign rise_w = act_w & ~prev_q;
  assign set_o  = level_i ? act_w : rise_w;

  // R8
  edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_o && !level_i) |=> (level_i || !set_o));

endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_q & ~clr_i)) |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0));

endmodule

// File: rtl/irq_route.sv
module irq_route import irq_router_pkg::*; #(
  parameter int NUM_SRC = 16,
  parameter int NUM_OUT = 8
) (
  input  logic [NUM_SRC-1:0]         pend_i,
  input  logic [NUM_SRC*FLD_W-1:0]   ctrl_i,
  input  logic [NUM_OUT-1:0]         outen_i,
  output logic [NUM_OUT*NUM_SRC-1:0] stat_o,
  output logic [NUM_OUT-1:0]         irq_o
);

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    logic [NUM_SRC-1:0] hit_w;
    logic [NUM_SRC-1:0] live_w;
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      src_fld_t f;
      assign f         = fld_of(ctrl_i[k*FLD_W +: FLD_W]);
      assign hit_w[k]  = pend_i[k] && (f.dest == DEST_W'(n));
      assign live_w[k] = hit_w[k] && f.en;
    end
    assign stat_o[n*NUM_SRC +: NUM_SRC] = hit_w;
    assign irq_o[n] = outen_i[n] && (|live_w);
  end

endmodule

// File: rtl/irq_regs.sv
module irq_regs import irq_router_pkg::*; #(
  parameter int NUM_SRC = 16,
  parameter int NUM_OUT = 8,
  parameter int NUM_EXT = 5,
  parameter int ADDR_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       we_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  input  logic [NUM_OUT*NUM_SRC-1:0] stat_i,
  output logic [NUM_SRC*FLD_W-1:0]   ctrl_o,
  output logic [NUM_OUT-1:0]         outen_o,
  output logic [2*NUM_EXT-1:0]       extcfg_o,
  output logic [NUM_SRC-1:0]         clr_o
);

  localparam int ROUTE_WORDS = (NUM_SRC * FLD_W) / 32;
  localparam int STAT_WORDS  = (NUM_OUT + 1) / 2;
  localparam int CFG_W       = 2 * NUM_EXT;
  localparam logic [NUM_SRC*FLD_W-1:0] EN_MASK = {NUM_SRC{4'b1000}};

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int byte_addr);
    return a == ADDR_W'(byte_addr);
  endfunction

  logic [NUM_SRC*FLD_W-1:0] ctrl_q;
  logic [NUM_OUT-1:0]       outen_q;
  logic [CFG_W-1:0]         cfg_q;
  logic                     map_wr_w;
  logic [31:0]              stat_word_w [STAT_WORDS];

  assign map_wr_w = we_i && hit(addr_i, AD_MAPALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      for (int w = 0; w < ROUTE_WORDS; w++) begin
        if (hit(addr_i, AD_ROUTE + 4*w)) ctrl_q[w*32 +: 32] <= wdata_i;
        if (map_wr_w) ctrl_q[w*32 +: 32] <= remap_word(ctrl_q[w*32 +: 32], wdata_i[DEST_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outen_q <= '0;
      cfg_q   <= '0;
    end else if (we_i) begin
      if (hit(addr_i, AD_OUTEN))  outen_q <= wdata_i[OUTEN_LSB +: NUM_OUT];
      if (hit(addr_i, AD_EXTCFG)) cfg_q   <= wdata_i[CFG_W-1:0];
    end
  end

  assign clr_o = (we_i && hit(addr_i, AD_CLEAR)) ? wdata_i[NUM_SRC-1:0] : '0;

  for (genvar j = 0; j < STAT_WORDS; j++) begin : g_sw
    logic [15:0] lo_w;
    logic [15:0] hi_w;
    assign lo_w = 16'(stat_i[2*j*NUM_SRC +: NUM_SRC]);
    if (2*j + 1 < NUM_OUT) begin : g_hi
      assign hi_w = 16'(stat_i[(2*j+1)*NUM_SRC +: NUM_SRC]);
    end else begin : g_nohi
      assign hi_w = '0;
    end
    assign stat_word_w[j] = pack_stat(lo_w, hi_w);
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < ROUTE_WORDS; w++)
      if (hit(addr_i, AD_ROUTE + 4*w)) rdata_o = ctrl_q[w*32 +: 32];
    for (int j = 0; j < STAT_WORDS; j++)
      if (hit(addr_i, AD_STAT + 4*j)) rdata_o = stat_word_w[j];
    if (hit(addr_i, AD_OUTEN))  rdata_o[OUTEN_LSB +: NUM_OUT] = outen_q;
    if (hit(addr_i, AD_EXTCFG)) rdata_o[CFG_W-1:0] = cfg_q;
  end

  assign ctrl_o   = ctrl_q;
  assign outen_o  = outen_q;
  assign extcfg_o = cfg_q;

  // R6
  mapall_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_w |=> ((ctrl_q & EN_MASK) == $past(ctrl_q & EN_MASK)));

  // R11
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !hit(addr_i, AD_ROUTE) && !hit(addr_i, AD_ROUTE + 4) && !map_wr_w)
      |=> $stable(ctrl_q));

endmodule

// File: rtl/irq_router.sv
module irq_router import irq_router_pkg::*; #(
  parameter int NUM_SRC     = 16,
  parameter int NUM_OUT     = 8,
  parameter int NUM_EXT     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_EXT-1:0]         ext_irq_i,
  input  logic [NUM_SRC-NUM_EXT-1:0] int_irq_i,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic [NUM_OUT-1:0]         cpu_irq_o
);

  logic [NUM_SRC*FLD_W-1:0]   ctrl_w;
  logic [NUM_OUT-1:0]         outen_w;
  logic [2*NUM_EXT-1:0]       cfg_w;
  logic [NUM_SRC-1:0]         clr_w;
  logic [NUM_SRC-1:0]         set_w;
  logic [NUM_SRC-1:0]         pend_w;
  logic [NUM_OUT*NUM_SRC-1:0] stat_w;

  irq_regs #(
    .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .NUM_EXT(NUM_EXT), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .addr_i(bus_addr), .we_i(bus_we), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .stat_i(stat_w), .ctrl_o(ctrl_w), .outen_o(outen_w), .extcfg_o(cfg_w),
    .clr_o(clr_w)
  );

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    irq_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n),
      .pin_i(ext_irq_i[i]),
      .low_act_i(cfg_w[2*i]),
      .level_i(cfg_w[2*i+1]),
      .set_o(set_w[i])
    );
  end

  assign set_w[NUM_SRC-1:NUM_EXT] = int_irq_i;

  irq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(clr_w), .pend_o(pend_w)
  );

  irq_route #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_route (
    .pend_i(pend_w), .ctrl_i(ctrl_w), .outen_i(outen_w),
    .stat_o(stat_w), .irq_o(cpu_irq_o)
  );

  // R3
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cpu_irq_o) |-> (|pend_w));

  // R10
  internal_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|int_irq_i) |=> ((pend_w[NUM_SRC-1:NUM_EXT] & $past(int_irq_i)) == $past(int_irq_i)));

endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
  localparam int NS = 16;
  localparam int NO = 8;
  localparam int NE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NE-1:0]    ext_in = '0;
  logic [NS-NE-1:0] int_in = '0;
  logic [7:0]       addr   = '0;
  logic             we     = 1'b0;
  logic [31:0]      wdata  = '0;
  wire  [31:0]      rdata;
  wire  [NO-1:0]    irq;

  irq_router u0 (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_in), .int_irq_i(int_in),
    .bus_addr(addr), .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
    .cpu_irq_o(irq)
  );

  int vectors = 0;
  int miscompares = 0;
  string req_tag = "R1";
  bit finished = 1'b0;

  // behavioural model state
  bit [3:0]      m_fld [NS];
  bit [NO-1:0]   m_oen;
  bit [2*NE-1:0] m_cfg;
  bit [NS-1:0]   m_pend;
  bit [NE-1:0]   m_last_act;
  bit [NE-1:0]   ext_hist[$];

  function automatic bit [NS-1:0] routed_to(int line);
    bit [NS-1:0] r = '0;
    foreach (m_fld[s]) if (m_pend[s] && int'(m_fld[s] & 4'h7) == line) r[s] = 1'b1;
    return r;
  endfunction

  function automatic bit [NO-1:0] exp_irq();
    bit [NO-1:0] r = '0;
    for (int line = 0; line < NO; line++) begin
      bit [NS-1:0] live = routed_to(line);
      for (int s = 0; s < NS; s++) if (!m_fld[s][3]) live[s] = 1'b0;
      r[line] = m_oen[line] && (live != 0);
    end
    return r;
  endfunction

  function automatic bit [31:0] exp_rdata(bit [7:0] a);
    bit [31:0] r = '0;
    case (a)
      8'h00: for (int s = 0; s < 8; s++) r = r | (32'(m_fld[s]) << (4*s));
      8'h04: for (int s = 0; s < 8; s++) r = r | (32'(m_fld[s+8]) << (4*s));
      8'h10, 8'h14, 8'h18, 8'h1C: begin
        int j = (int'(a) - 16) / 4;
        r = {routed_to(2*j+1), routed_to(2*j)};
      end
      8'h20: r = 32'(m_oen) << 16;
      8'h24: r = 32'(m_cfg);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic model_reset();
    foreach (m_fld[s]) m_fld[s] = '0;
    m_oen = '0; m_cfg = '0; m_pend = '0; m_last_act = '0;
    ext_hist.delete();
  endtask

  // one clock edge of the model, using values present before the edge
  task automatic model_edge();
    bit [NE-1:0] seen;
    bit [NE-1:0] act;
    bit [NS-1:0] setv;
    bit [NS-1:0] clr;
    setv = '0;
    ext_hist.push_back(ext_in);
    if (ext_hist.size() > 4) void'(ext_hist.pop_front());
    seen = (ext_hist.size() >= 3) ? ext_hist[ext_hist.size()-3] : '0;
    for (int i = 0; i < NE; i++) begin
      act[i] = seen[i] ^ m_cfg[2*i];
      if (m_cfg[2*i+1]) setv[i] = act[i];
      else              setv[i] = act[i] && !m_last_act[i];
    end
    m_last_act = act;
    for (int k = NE; k < NS; k++) setv[k] = int_in[k-NE];
    clr = (we && addr == 8'h0C) ? wdata[NS-1:0] : '0;
    m_pend = (m_pend & ~clr) | setv;
    if (we) begin
      case (addr)
        8'h00: for (int s = 0; s < 8; s++) m_fld[s]   = wdata[4*s +: 4];
        8'h04: for (int s = 0; s < 8; s++) m_fld[s+8] = wdata[4*s +: 4];
        8'h08: foreach (m_fld[s]) m_fld[s] = {m_fld[s][3], wdata[2:0]};
        8'h20: m_oen = wdata[23:16];
        8'h24: m_cfg = wdata[2*NE-1:0];
        default: ;
      endcase
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({req_tag, " cpu lines"}, 32'(irq), 32'(exp_irq()));
    chk({req_tag, " read data"}, rdata, exp_rdata(addr));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; we = 1'b1; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] e);
    addr = a;
    #1;
    chk(tag, rdata, e);
  endtask

  task automatic irq_chk(string tag, logic [7:0] e);
    chk(tag, 32'(irq), 32'(e));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    model_reset();
    repeat (3) @(negedge clk);
    irq_chk("R1 lines low in reset", 8'h00);
    rst_n = 1'b1;

    // R1 reset state
    req_tag = "R1";
    irq_chk("R1 lines after reset", 8'h00);
    rd_chk("R1 route0", 8'h00, 32'h0);
    rd_chk("R1 route1", 8'h04, 32'h0);
    rd_chk("R1 stat01", 8'h10, 32'h0);
    rd_chk("R1 stat67", 8'h1C, 32'h0);
    rd_chk("R1 outen", 8'h20, 32'h0);
    rd_chk("R1 extcfg", 8'h24, 32'h0);

    // R2 routing words
    req_tag = "R2";
    wr(8'h00, 32'hFEDC_BA98);
    rd_chk("R2 route0 readback", 8'h00, 32'hFEDC_BA98);
    wr(8'h04, 32'h1234_5678);
    rd_chk("R2 route1 readback", 8'h04, 32'h1234_5678);

    // R6 retarget all, enables kept
    req_tag = "R6";
    wr(8'h08, 32'h0000_0003);
    rd_chk("R6 route0 after retarget", 8'h00, 32'hBBBB_BBBB);
    rd_chk("R6 route1 after retarget", 8'h04, 32'h3333_333B);
    rd_chk("R6 retarget reads zero", 8'h08, 32'h0);

    // R10 / R3 / R4 internal source 8 -> line 2
    req_tag = "R10";
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0000_000A);
    wr(8'h20, 32'h0004_0000);
    rd_chk("R3 line enable readback", 8'h20, 32'h0004_0000);
    int_in[3] = 1'b1;
    tick();
    int_in[3] = 1'b0;
    irq_chk("R10 internal strobe raises line 2", 8'h04);
    tick();
    irq_chk("R10 pending stays after strobe", 8'h04);
    rd_chk("R4 status lines 2/3", 8'h14, 32'h0000_0100);
    rd_chk("R4 status lines 0/1", 8'h10, 32'h0);

    req_tag = "R4";
    wr(8'h04, 32'h0000_0002);
    irq_chk("R3 disabled source drives nothing", 8'h00);
    rd_chk("R4 disabled source still in status", 8'h14, 32'h0000_0100);
    wr(8'h04, 32'h0000_000A);
    irq_chk("R3 re-enabled source", 8'h04);

    req_tag = "R3";
    wr(8'h20, 32'h0);
    irq_chk("R3 line enable off", 8'h00);
    wr(8'h20, 32'h0004_0000);
    irq_chk("R3 line enable on", 8'h04);

    // R5 write-one clear
    req_tag = "R5";
    wr(8'h0C, 32'h0000_FEFF);
    irq_chk("R5 zero bit leaves source", 8'h04);
    wr(8'h0C, 32'h0000_0100);
    irq_chk("R5 one bit clears source", 8'h00);
    rd_chk("R5 status after clear", 8'h14, 32'h0);
    rd_chk("R5 clear reads zero", 8'h0C, 32'h0);
    int_in[3] = 1'b1;
    wr(8'h0C, 32'h0000_0100);
    int_in[3] = 1'b0;
    irq_chk("R5 set wins over clear", 8'h04);
    wr(8'h0C, 32'h0000_0100);
    irq_chk("R5 clear after collision", 8'h00);

    // R7 / R8 edge mode, active high, source 0 -> line 4
    req_tag = "R7";
    wr(8'h00, 32'h0000_000C);
    wr(8'h20, 32'h0010_0000);
    ext_in[0] = 1'b1;
    tick(); tick();
    irq_chk("R7 not yet after two edges", 8'h00);
    tick();
    irq_chk("R7 pending on third edge", 8'h10);
    req_tag = "R8";
    ext_in[0] = 1'b0;
    repeat (4) tick();
    irq_chk("R8 edge pending holds", 8'h10);
    wr(8'h0C, 32'h0000_0001);
    irq_chk("R8 edge cleared", 8'h00);
    repeat (4) tick();
    irq_chk("R8 no re-fire without new edge", 8'h00);

    // R9 level mode
    req_tag = "R9";
    wr(8'h24, 32'h0000_0002);
    ext_in[0] = 1'b1;
    repeat (3) tick();
    irq_chk("R9 level pending", 8'h10);
    wr(8'h0C, 32'h0000_0001);
    irq_chk("R9 clear while active has no effect", 8'h10);
    ext_in[0] = 1'b0;
    repeat (3) tick();
    irq_chk("R9 still pending after release", 8'h10);
    wr(8'h0C, 32'h0000_0001);
    irq_chk("R9 clear after release", 8'h00);

    // R7 polarity: source 1 edge, active low
    req_tag = "R7";
    wr(8'h00, 32'h0000_00C0);
    wr(8'h24, 32'h0000_0004);
    tick();
    irq_chk("R7 low pin active after inversion", 8'h10);
    wr(8'h0C, 32'h0000_0002);
    irq_chk("R7 cleared", 8'h00);
    ext_in[1] = 1'b1;
    repeat (4) tick();
    irq_chk("R7 high pin inactive when inverted", 8'h00);
    ext_in[1] = 1'b0;
    tick(); tick();
    irq_chk("R7 falling edge two edges in", 8'h00);
    tick();
    irq_chk("R7 falling edge latched", 8'h10);
    wr(8'h0C, 32'h0000_0002);

    // R11 unmapped space and unimplemented bits
    req_tag = "R11";
    rd_chk("R11 unmapped read", 8'h30, 32'h0);
    wr(8'h30, 32'hFFFF_FFFF);
    rd_chk("R11 unmapped write leaves route0", 8'h00, 32'h0000_00C0);
    wr(8'h20, 32'hFFFF_FFFF);
    rd_chk("R11 line enable field only", 8'h20, 32'h00FF_0000);
    rd_chk("R11 config before write", 8'h24, 32'h0000_0004);
    wr(8'h24, 32'hFFFF_FFFF);
    rd_chk("R11 config field only", 8'h24, 32'h0000_03FF);
    wr(8'h24, 32'h0);
    wr(8'h0C, 32'h0000_FFFF);

    // mixed traffic against the model
    req_tag = "R3";
    seed = 32'h1357_9BDF;
    for (int i = 0; i < 6000; i++) begin
      int unsigned r1, r2;
      seed = seed * 1103515245 + 12345; r1 = seed;
      seed = seed * 1103515245 + 12345; r2 = seed;
      if (r1[3:0] == 4'h0) ext_in[r1[6:4] % NE] = ~ext_in[r1[6:4] % NE];
      int_in = (r1[3:0] < 4'h3) ? r2[10:0] & r1[26:16] : '0;
      we = (r1[9:7] < 3'd3);
      case (r2[14:11])
        4'd0, 4'd1: addr = 8'h00;
        4'd2:       addr = 8'h04;
        4'd3:       addr = 8'h08;
        4'd4, 4'd5: addr = 8'h0C;
        4'd6:       addr = 8'h10;
        4'd7:       addr = 8'h14;
        4'd8:       addr = 8'h18;
        4'd9:       addr = 8'h1C;
        4'd10:      addr = 8'h20;
        4'd11:      addr = 8'h24;
        4'd12:      addr = 8'h2C;
        default:    addr = 8'h14;
      endcase
      wdata = {r2[31:16], r1[31:16]};
      tick();
    end
    we = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule